// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned N-bit numbers over a series of clock cycles. It holds the multiplicand in a register, the multiplier in a shift register, and the upper half of the product in an accumulator. A one-cycle start request, given while the block is idle, captures both operands and clears the accumulator. Each following cycle then processes one multiplier bit.

In each iteration the lowest bit of the multiplier register is tested. When that bit is set, the multiplicand is added into the accumulator. The adder's carry-out, the accumulator and the multiplier register then shift right together as one unit. Low product bits therefore move into the multiplier register as the used multiplier bits drop off its bottom end. After N iterations the accumulator holds the upper half of the 2N-bit product and the multiplier register holds the lower half. A one-cycle completion pulse marks the result. The result stays on the output until another start is accepted.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is high, and on the first cycle after it, `busy`, `done` and all bits of `product` are 0.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is 1 after that edge, and the operand inputs are captured there, so later changes on them have no effect on the result.
- R3: After an accepted start, exactly N iterations run. `done` first reads 1 after the N-th clock edge following the accepting edge, and `busy` is 1 for exactly those N cycles.
- R4: `done` is high for exactly one cycle per operation, and `busy` is 0 whenever `done` is 1.
- R5: When `done` is 1, `product` equals the unsigned product of the captured multiplicand and multiplier. Bits [2N-1:N] come from the accumulator and bits [N-1:0] come from the multiplier register.
- R6: A `start` that arrives while `busy` is 1 is ignored. It changes neither the timing of `done` nor the result.
- R7: If either operand is zero, the operation still takes N iterations and the result is zero.
- R8: While the block is idle and no start is accepted, `product` holds its value.
- R9: A `start` given in the same cycle as `done` is accepted. The next operation begins at once.
- R10: With both operands at their all-ones maximum, the carry-out of each addition is kept in the result, giving (2^N-1)^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication; honoured only when idle |
| multiplicand | input | N | Unsigned multiplicand, captured on accept |
| multiplier | input | N | Unsigned multiplier, captured on accept |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2N | Accumulator (high half) concatenated with multiplier register (low half) |

## Verification
The bench counts edges from the accepting edge to `done`. An off-by-one iteration count would show up either as a late or early pulse or as a product shifted by one place. It feeds all-ones operands, so a design that drops the adder's carry during the shift returns a wrong top half. It also feeds zero operands, which would catch a design that terminates early or leaves stale data in the accumulator. It pulses `start` mid-operation and changes the operand pins, which exposes a design that restarts or re-samples its inputs. It also issues a start in the cycle of `done`, to catch a controller that needs an idle cycle before it will accept.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } mul_ctrl_t;

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output mul_ctrl_t ctrl,
    output logic      busy,
    output logic      done
);
    localparam int CW = $clog2(N + 1);

    mul_state_e    state;
    logic [CW-1:0] left;

    always_comb begin
        ctrl.load = (state == MS_IDLE) && start;
        ctrl.step = (state == MS_RUN);
    end

    assign busy = (state == MS_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MS_IDLE;
            left  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                MS_IDLE: begin
                    if (start) begin
                        state <= MS_RUN;
                        left  <= CW'(N);
                    end
                end
                MS_RUN: begin
                    left <= left - 1'b1;
                    if (left == CW'(1)) begin
                        state <= MS_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
    import mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  mul_ctrl_t     ctrl,
    input  logic [N-1:0]  mcand_in,
    input  logic [N-1:0]  mplier_in,
    output logic [2*N-1:0] result
);
    logic [N-1:0] ra_q;
    logic [N-1:0] rb_q;
    logic [N-1:0] q_q;
    logic [N-1:0] addend;
    logic [N:0]   sum;

    // Gate each multiplicand bit with the multiplier bit under test.
    for (genvar i = 0; i < N; i++) begin : g_addend
        assign addend[i] = ra_q[i] & q_q[0];
    end

    assign sum = {1'b0, rb_q} + {1'b0, addend};

    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q <= '0;
            rb_q <= '0;
            q_q  <= '0;
        end else if (ctrl.load) begin
            ra_q <= mcand_in;
            rb_q <= '0;
            q_q  <= mplier_in;
        end else if (ctrl.step) begin
            // carry-out into accumulator MSB, accumulator LSB into Q MSB
            rb_q <= sum[N:1];
            q_q  <= {sum[0], q_q[N-1:1]};
        end
    end

    assign result = {rb_q, q_q};

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   multiplicand,
    input  logic [N-1:0]   multiplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    mul_ctrl_t ctrl;

    mul_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl),
        .busy  (busy),
        .done  (done)
    );

    mul_datapath #(.N(N)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .result    (product)
    );

endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   multiplicand,
    input logic [N-1:0]   multiplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int PW = 2 * N;
    localparam int CW = $clog2(N + 2);

    logic [CW-1:0] run_cnt;
    logic [PW-1:0] want;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            want    <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            want    <= PW'(multiplicand) * PW'(multiplier);
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r3_iteration_count: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == CW'(N)));

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r5_product_value: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == want));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

endmodule

bind shift_add_mul mul_checker #(.N(N)) u_mul_checker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
);

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
    localparam int N  = 8;
    localparam int PW = 2 * N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [N-1:0]  mcand = '0;
    logic [N-1:0]  mplier = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [PW-1:0] last_prod = '0;

    always #5 clk = ~clk;

    shift_add_mul #(.N(N)) uut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .multiplicand (mcand),
        .multiplier   (mplier),
        .busy         (busy),
        .done         (done),
        .product      (product)
    );

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        return PW'(a) * PW'(b);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge where done is expected.
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit poke_busy);
        logic [PW-1:0] exp_p;
        exp_p  = ref_mul(a, b);
        start  = 1'b1;
        mcand  = a;
        mplier = b;
        @(negedge clk);
        start = 1'b0;
        // R2: operands captured; scramble pins afterwards
        mcand  = N'($urandom);
        mplier = N'($urandom);
        check(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
        check(done == 1'b0, "R3 done early", 64'(done), 64'd0);
        for (int i = 1; i < N; i++) begin
            start = (poke_busy && i == 2);  // R6: start while busy
            @(negedge clk);
            check(done == 1'b0, "R3 done before N iterations", 64'(done), 64'd0);
            check(busy == 1'b1, "R3 busy during run", 64'(busy), 64'd1);
        end
        start = 1'b0;
        @(negedge clk);
        check(done == 1'b1, "R3 done after N iterations", 64'(done), 64'd1);
        check(busy == 1'b0, "R4 busy low with done", 64'(busy), 64'd0);
        check(product == exp_p, poke_busy ? "R6 result after ignored start" : "R5 product",
              64'(product), 64'(exp_p));
        last_prod = product;
    endtask

    task automatic idle_hold();
        mcand  = N'($urandom);
        mplier = N'($urandom);
        @(negedge clk);
        check(done == 1'b0, "R4 done single cycle", 64'(done), 64'd0);
        check(product == last_prod, "R8 product held while idle", 64'(product), 64'(last_prod));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 state in reset",
              64'({busy, done, product}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 state after reset",
              64'({busy, done, product}), 64'd0);

        run_op(8'd13, 8'd11, 1'b0);            // R5 directed
        idle_hold();
        run_op('1, '1, 1'b0);                  // R10 all ones
        check(product == PW'(16'hFE01), "R10 max operands", 64'(product), 64'hFE01);
        idle_hold();
        run_op('0, 8'd200, 1'b0);              // R7 zero multiplicand
        check(product == '0, "R7 zero multiplicand", 64'(product), 64'd0);
        idle_hold();
        run_op(8'd77, '0, 1'b0);               // R7 zero multiplier
        check(product == '0, "R7 zero multiplier", 64'(product), 64'd0);
        idle_hold();
        run_op(8'd99, 8'd3, 1'b1);             // R6 ignored start
        idle_hold();
        run_op(8'd128, 8'd255, 1'b0);
        run_op(8'd45, 8'd201, 1'b0);           // R9 start in done cycle
        idle_hold();

        for (int k = 0; k < 40; k++) begin
            logic [N-1:0] ra;
            logic [N-1:0] rq;
            ra = N'($urandom);
            rq = N'($urandom);
            run_op(ra, rq, (k % 5) == 0);
            if (k % 3 != 0) idle_hold();
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule